// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Port

This block lets a host reach a device-internal memory and a bank of internal peripheral registers through a small set of host-visible registers. The host loads a pointer register and then reads or writes a data register. Each data-register access completes one 32-bit transfer on the internal side.

For the memory window, reading and writing each have their own pointer. Every access to the matching data register moves one word and advances that pointer by one word. The peripheral window uses a 16-bit register offset plus a two-bit field that holds the byte count minus one. Peripheral pointers stay put between accesses, and partial writes drive only the low-order byte lanes.

Host register offsets are byte offsets: 0x00 memory read pointer, 0x04 memory write pointer, 0x08 memory write data, 0x0C memory read data, 0x10 peripheral read address, 0x14 peripheral write address, 0x18 peripheral write data, 0x1C peripheral read data. Every host read answers with `host_rvalid` and `host_rdata` in the cycle after the request.

Top module: `indirect_mem_port`

## Requirements
- R1: A host write to 0x00 or 0x04 loads the memory read or write pointer (a word address, all MEM_AW bits used). A host read of the same offset returns the pointer.
- R2: A host write to 0x08 drives one cycle of `mem_wr` with `mem_addr` equal to the write pointer and `mem_wdata` equal to the host data. The write pointer then advances by one.
- R3: A host read of 0x0C drives one cycle of `mem_rd` at the read pointer. The word the memory returns on the following cycle appears on `host_rdata` with `host_rvalid` high, and the read pointer advances by one.
- R4: A memory write access never changes the read pointer, and a memory read access never changes the write pointer.
- R5: A pointer at its all-ones value wraps to zero after an access.
- R6: Peripheral address registers (0x10 read, 0x14 write) keep bits [PRPH_AW-1:0] as the offset and bits [25:24] as the byte count minus one. All other bits read back as zero.
- R7: A host write to 0x18 drives `prph_wr` at the write offset. `prph_be` enables the low count+1 byte lanes (count 0 -> 0001, 1 -> 0011, 2 -> 0111, 3 -> 1111).
- R8: A host read of 0x1C drives `prph_rd` at the read offset with strobes formed as in R7. The next-cycle result zeroes every byte above the count.
- R9: Peripheral offsets do not advance on data accesses. Repeated accesses hit the same register.
- R10: After reset, all pointers and fields are zero, no strobe is active and `host_rvalid` is low.
- R11: The following have no effect on any pointer or internal port: host writes to 0x0C or 0x1C, host reads of 0x08 or 0x18, and accesses whose address bits [1:0] are not zero. Such reads return zero. When write and read are requested together, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read result valid, one cycle after host_rd |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| prph_wr | output | 1 | Peripheral write strobe |
| prph_rd | output | 1 | Peripheral read strobe |
| prph_addr | output | PRPH_AW | Peripheral register offset |
| prph_be | output | 4 | Peripheral byte lane enables |
| prph_wdata | output | 32 | Peripheral write data |
| prph_rdata | input | 32 | Peripheral read data, one cycle after prph_rd |

## Verification
The hardest case to reach is interleaving, where the two memory pointers have been set to different places and the stream of reads and writes is mixed. A fault that moves the wrong pointer stays hidden until a later read lands on a stale word. The stimulus loads the pointers apart, writes a burst, then alternates reads and writes. It reads both pointers back between steps. Pointer wrap is forced by loading all-ones. Partial peripheral writes are checked against a shadow copy that merges only the enabled bytes, and the same offset is read back at different counts.

// File: rtl/indirect_mem_port.sv
module indirect_mem_port #(
  parameter int MEM_AW  = 32,
  parameter int PRPH_AW = 16,
  parameter int HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               host_rvalid,
  output logic               mem_wr,
  output logic               mem_rd,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic               prph_wr,
  output logic               prph_rd,
  output logic [PRPH_AW-1:0] prph_addr,
  output logic [3:0]         prph_be,
  output logic [31:0]        prph_wdata,
  input  logic [31:0]        prph_rdata
);
  localparam int IDX_W = HOST_AW - 2;
  localparam logic [IDX_W-1:0] I_MRP = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_MWP = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_MWD = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_MRD = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_PRA = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_PWA = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_PWD = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_PRD = IDX_W'(7);
  localparam logic [1:0] SRC_REG = 2'd0, SRC_MEM = 2'd1, SRC_PRPH = 2'd2;

  function automatic logic [3:0] lanes(input logic [1:0] cnt);
    case (cnt)
      2'd0:    lanes = 4'b0001;
      2'd1:    lanes = 4'b0011;
      2'd2:    lanes = 4'b0111;
      default: lanes = 4'b1111;
    endcase
  endfunction

  logic [MEM_AW-1:0]  mr_ptr, mw_ptr;
  logic [PRPH_AW-1:0] pr_off, pw_off;
  logic [1:0]         pr_cnt, pw_cnt;
  logic               rvalid_q;
  logic [1:0]         src_q;
  logic [31:0]        reg_q;
  logic [3:0]         be_q;
  logic [31:0]        reg_view;

  wire [IDX_W-1:0] idx  = host_addr[HOST_AW-1:2];
  wire             hit  = host_addr[1:0] == 2'b00;
  wire             wr_a = host_wr & hit;
  wire             rd_q = host_rd & ~host_wr;
  wire             rd_a = rd_q & hit;

  wire [7:0] unused_wbits = {host_wdata[31:26], host_wdata[23:22]} ^ 8'(host_wdata[21:PRPH_AW]);

  assign mem_wr     = wr_a && idx == I_MWD;
  assign mem_rd     = rd_a && idx == I_MRD;
  assign mem_addr   = mem_wr ? mw_ptr : mr_ptr;
  assign mem_wdata  = host_wdata;
  assign prph_wr    = wr_a && idx == I_PWD;
  assign prph_rd    = rd_a && idx == I_PRD;
  assign prph_addr  = prph_wr ? pw_off : pr_off;
  assign prph_be    = prph_wr ? lanes(pw_cnt) : lanes(pr_cnt);
  assign prph_wdata = host_wdata;

  always_comb begin
    case (idx)
      I_MRP:   reg_view = 32'(mr_ptr);
      I_MWP:   reg_view = 32'(mw_ptr);
      I_PRA:   reg_view = {6'b0, pr_cnt, 8'b0, 16'(pr_off)};
      I_PWA:   reg_view = {6'b0, pw_cnt, 8'b0, 16'(pw_off)};
      default: reg_view = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_ptr <= '0;
      mw_ptr <= '0;
      pr_off <= '0;
      pw_off <= '0;
      pr_cnt <= '0;
      pw_cnt <= '0;
    end else begin
      if (wr_a && idx == I_MRP) mr_ptr <= host_wdata[MEM_AW-1:0];
      if (wr_a && idx == I_MWP) mw_ptr <= host_wdata[MEM_AW-1:0];
      if (wr_a && idx == I_PRA) begin
        pr_off <= host_wdata[PRPH_AW-1:0];
        pr_cnt <= host_wdata[25:24];
      end
      if (wr_a && idx == I_PWA) begin
        pw_off <= host_wdata[PRPH_AW-1:0];
        pw_cnt <= host_wdata[25:24];
      end
      if (mem_wr) mw_ptr <= mw_ptr + 1'b1;
      if (mem_rd) mr_ptr <= mr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      src_q    <= SRC_REG;
      reg_q    <= '0;
      be_q     <= '0;
    end else begin
      rvalid_q <= rd_q;
      src_q    <= mem_rd ? SRC_MEM : prph_rd ? SRC_PRPH : SRC_REG;
      reg_q    <= hit ? reg_view : '0;
      be_q     <= lanes(pr_cnt);
    end
  end

  wire [31:0] lane_mask = {{8{be_q[3]}}, {8{be_q[2]}}, {8{be_q[1]}}, {8{be_q[0]}}};

  assign host_rvalid = rvalid_q;
  assign host_rdata  = !rvalid_q          ? '0 :
                       src_q == SRC_MEM   ? mem_rdata :
                       src_q == SRC_PRPH  ? (prph_rdata & lane_mask) : reg_q;
endmodule

module indirect_mem_port_chk #(
  parameter int MEM_AW  = 32,
  parameter int PRPH_AW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_wr,
  input logic               mem_rd,
  input logic               prph_wr,
  input logic               prph_rd,
  input logic [3:0]         prph_be,
  input logic               host_rvalid,
  input logic [MEM_AW-1:0]  mw_ptr,
  input logic [MEM_AW-1:0]  mr_ptr,
  input logic [PRPH_AW-1:0] pw_off,
  input logic [PRPH_AW-1:0] pr_off
);
  assert_wptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> mw_ptr == $past(mw_ptr) + 1'b1);
  assert_rptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mr_ptr == $past(mr_ptr) + 1'b1);
  assert_rvalid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> host_rvalid);
  assert_rd_keeps_wptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(mw_ptr));
  assert_wr_keeps_rptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(mr_ptr));
  assert_lane_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prph_wr |-> (prph_be == 4'b0001 || prph_be == 4'b0011 ||
                 prph_be == 4'b0111 || prph_be == 4'b1111));
  assert_offset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prph_wr || prph_rd) |=> ($stable(pw_off) && $stable(pr_off)));
  assert_single_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd, prph_wr, prph_rd}));
endmodule

bind indirect_mem_port indirect_mem_port_chk #(.MEM_AW(MEM_AW), .PRPH_AW(PRPH_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .mem_rd(mem_rd),
  .prph_wr(prph_wr), .prph_rd(prph_rd), .prph_be(prph_be),
  .host_rvalid(host_rvalid), .mw_ptr(mw_ptr), .mr_ptr(mr_ptr),
  .pw_off(pw_off), .pr_off(pr_off)
);

// File: tb/test_indirect_mem_port.sv
module test_indirect_mem_port;
  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [4:0]  host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata, mem_wdata, prph_wdata;
  logic        host_rvalid, mem_wr, mem_rd, prph_wr, prph_rd;
  logic [31:0] mem_addr;
  logic [15:0] prph_addr;
  logic [3:0]  prph_be;
  logic [31:0] mem_rdata = 0, prph_rdata = 0;

  int tests = 0, fails = 0;

  indirect_mem_port i_indirect_mem_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .prph_wr(prph_wr), .prph_rd(prph_rd), .prph_addr(prph_addr),
    .prph_be(prph_be), .prph_wdata(prph_wdata), .prph_rdata(prph_rdata));

  always #5 clk = ~clk;

  logic [31:0] mem_model [0:63];
  logic [31:0] prph_model [0:15];
  always @(posedge clk) begin
    if (mem_wr) mem_model[mem_addr[5:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem_model[mem_addr[5:0]];
    if (prph_wr)
      for (int b = 0; b < 4; b++)
        if (prph_be[b]) prph_model[prph_addr[3:0]][8*b +: 8] <= prph_wdata[8*b +: 8];
    if (prph_rd) prph_rdata <= prph_model[prph_addr[3:0]];
  end

  // reference state
  logic [31:0] rp = 0, wp = 0;
  logic [15:0] pr_off = 0, pw_off = 0;
  logic [1:0]  pr_cnt = 0, pw_cnt = 0;
  logic [31:0] exp_mem [0:63];
  logic [31:0] exp_prph [0:15];
  logic e_mw = 0, e_mr = 0, e_pw = 0, e_pr = 0, e_rvalid = 0;

  function automatic logic [3:0] be_of(input logic [1:0] c);
    return 4'hF >> (2'd3 - c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) e_rvalid <= rst_n && host_rd && !host_wr;

  always @(negedge clk) begin
    #2;
    check("R10/R11 mem_wr strobe", 32'(mem_wr), 32'(e_mw));
    check("R10/R11 mem_rd strobe", 32'(mem_rd), 32'(e_mr));
    check("R10/R11 prph_wr strobe", 32'(prph_wr), 32'(e_pw));
    check("R10/R11 prph_rd strobe", 32'(prph_rd), 32'(e_pr));
    check("R3 host_rvalid timing", 32'(host_rvalid), 32'(e_rvalid));
    if (e_mw) begin
      check("R2 mem_addr", mem_addr, wp);
      check("R2 mem_wdata", mem_wdata, host_wdata);
    end
    if (e_mr) check("R3 mem_addr", mem_addr, rp);
    if (e_pw) begin
      check("R7 prph_addr", 32'(prph_addr), 32'(pw_off));
      check("R7 prph_be", 32'(prph_be), 32'(be_of(pw_cnt)));
    end
    if (e_pr) begin
      check("R8 prph_addr", 32'(prph_addr), 32'(pr_off));
      check("R8 prph_be", 32'(prph_be), 32'(be_of(pr_cnt)));
    end
  end

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    e_mw = (a == 5'h08); e_pw = (a == 5'h18);
    @(negedge clk);
    host_wr = 0; e_mw = 0; e_pw = 0;
    case (a)
      5'h00: rp = d;
      5'h04: wp = d;
      5'h08: begin exp_mem[wp[5:0]] = d; wp = wp + 1; end
      5'h10: begin pr_off = d[15:0]; pr_cnt = d[25:24]; end
      5'h14: begin pw_off = d[15:0]; pw_cnt = d[25:24]; end
      5'h18: for (int b = 0; b < 4; b++)
               if (be_of(pw_cnt)[b]) exp_prph[pw_off[3:0]][8*b +: 8] = d[8*b +: 8];
      default: ;
    endcase
  endtask

  task automatic hr(input logic [4:0] a, input string req);
    logic [31:0] exp;
    case (a)
      5'h00: exp = rp;
      5'h04: exp = wp;
      5'h0C: exp = exp_mem[rp[5:0]];
      5'h10: exp = {6'b0, pr_cnt, 8'b0, pr_off};
      5'h14: exp = {6'b0, pw_cnt, 8'b0, pw_off};
      5'h1C: exp = exp_prph[pr_off[3:0]] & {{8{be_of(pr_cnt)[3]}}, {8{be_of(pr_cnt)[2]}},
                                            {8{be_of(pr_cnt)[1]}}, {8{be_of(pr_cnt)[0]}}};
      default: exp = 0;
    endcase
    @(negedge clk);
    host_rd = 1; host_addr = a;
    e_mr = (a == 5'h0C); e_pr = (a == 5'h1C);
    @(negedge clk);
    host_rd = 0; e_mr = 0; e_pr = 0;
    if (a == 5'h0C) rp = rp + 1;
    #1;
    check(req, host_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem_model[i] = 0; exp_mem[i] = 0; end
    for (int i = 0; i < 16; i++) begin prph_model[i] = 0; exp_prph[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    hr(5'h00, "R10 read pointer reset");
    hr(5'h04, "R10 write pointer reset");
    hr(5'h10, "R10 prph read address reset");
    hr(5'h14, "R10 prph write address reset");
    // R1 R2 burst write
    hw(5'h04, 32'h10);
    hr(5'h04, "R1 write pointer load");
    hw(5'h08, 32'hA0A0_0001);
    hw(5'h08, 32'hB0B0_0002);
    hw(5'h08, 32'hC0C0_0003);
    hw(5'h08, 32'hD0D0_0004);
    hr(5'h04, "R2 write pointer advanced");
    // R3 R4 interleaved
    hw(5'h00, 32'h10);
    hr(5'h00, "R1 read pointer load");
    hr(5'h0C, "R3 first read word");
    hr(5'h0C, "R3 second read word");
    hr(5'h00, "R3 read pointer advanced");
    hr(5'h04, "R4 write pointer untouched by reads");
    hw(5'h08, 32'hE0E0_0005);
    hr(5'h00, "R4 read pointer untouched by write");
    hr(5'h0C, "R3 third read word");
    hw(5'h08, 32'hF0F0_0006);
    hr(5'h0C, "R3 fourth read word");
    hr(5'h0C, "R4 read sees interleaved write");
    hr(5'h04, "R4 write pointer after interleave");
    // R5 wrap
    hw(5'h04, 32'hFFFF_FFFF);
    hw(5'h08, 32'h5A5A_5A5A);
    hr(5'h04, "R5 write pointer wrap");
    hw(5'h00, 32'hFFFF_FFFF);
    hr(5'h0C, "R5 read at top address");
    hr(5'h00, "R5 read pointer wrap");
    // R6 peripheral address fields
    hw(5'h14, 32'hFFFF_0005);
    hr(5'h14, "R6 prph write address fields");
    hw(5'h18, 32'h1122_3344);
    hw(5'h14, 32'h0100_0005);
    hw(5'h18, 32'hAABB_CCDD);
    hw(5'h10, 32'h0300_0005);
    hr(5'h1C, "R7 partial write kept upper bytes");
    hw(5'h14, 32'h0200_0007);
    hw(5'h18, 32'h9988_7766);
    hw(5'h10, 32'h0300_0007);
    hr(5'h1C, "R7 three-byte write");
    hw(5'h10, 32'h0000_0005);
    hr(5'h1C, "R8 one-byte read masked");
    hr(5'h1C, "R9 repeated read same offset");
    hr(5'h10, "R9 prph read address unchanged");
    hw(5'h10, 32'h0100_0005);
    hr(5'h1C, "R8 two-byte read masked");
    hr(5'h14, "R9 prph write address unchanged");
    // R11 ignored accesses
    hw(5'h0C, 32'h1234_5678);
    hr(5'h00, "R11 write to read-data ignored");
    hw(5'h1C, 32'h1234_5678);
    hr(5'h08, "R11 read of write-data returns zero");
    hr(5'h04, "R11 write pointer kept");
    hw(5'h05, 32'h0000_0033);
    hr(5'h04, "R11 misaligned write ignored");
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule